// File: doc/BRIEF.md
# Table-Driven Bus Wait-State Controller

This block paces a bus transfer by inserting wait states between a request and its acknowledge. A two-bit state register holds the present phase. A sixteen-word by four-bit constant lookup table supplies both the next phase and the two handshake outputs.

The table is addressed by the present phase concatenated with the request and wait inputs. Each word carries the next phase in its upper two bits and the outputs in its lower two. Because the outputs come straight from the table, they react to the inputs within the same cycle, as in a Mealy machine. The register advances on a rising clock edge only while the step enable is high. An active-high asynchronous reset returns it to idle.

All pins are plain control signals with no valid/ready flow. There is no data stream to back-pressure. The step enable is the only means of stalling the controller, and while it is low the phase is frozen.

Top module: `wsg_top`

## Requirements
- R1: In the idle phase (00) with `req` high, the phase stays 00 and `ret` and `ack` are both 0 (word 0x0).
- R2: In the idle phase with `req` low, the next phase is 01 and `ret` is 1 and `ack` is 0 (word 0x6).
- R3: In the wait phase (01) with `pwait` low, the phase stays 01 with `ret` 1 and `ack` 0 for any `req`, however many cycles `pwait` stays low.
- R4: In the wait phase with `pwait` high, the next phase is 10 with `ack` 1 and `ret` 0 (word 0x9); `ret` and `ack` are never high together.
- R5: In the done phase (10), the next phase is 00 and both outputs are 0 for every input combination.
- R6: The phase changes only on a rising `clk` edge with `step_en` high; with `step_en` low it holds, while the outputs keep following the inputs.
- R7: Raising `rst` forces the phase to 00 at once, without waiting for a clock edge.
- R8: `ret` and `ack` are combinational functions of the phase, `req` and `pwait`, and change within a cycle when an input changes.
- R9: The table address is {B, A, req, pwait} from MSB to LSB, where {B, A} is the present phase. Each word is {next B, next A, ret, ack} from MSB to LSB. Addresses 12 to 15 (phase 11) hold 0x0, so phase 11 is left for 00 at the next enabled edge and is never entered from a legal phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high, forces idle |
| step_en | input | 1 | Clock enable for the phase register |
| req | input | 1 | Request input (low starts a transfer from idle) |
| pwait | input | 1 | Wait input (high ends the wait phase) |
| ret | output | 1 | Retry/hold output |
| ack | output | 1 | Acknowledge output |

## Verification
A behavioural phase model in the bench is stepped alongside the design. The outputs are compared on every cycle under three kinds of stimulus:
- Directed transfers tell the idle hold apart from the start of a transfer.
- Wait periods held for several cycles with `req` toggling show that `req` is ignored while waiting, and distinguish a stretched wait from an immediate acknowledge.
- Long runs of random inputs with random enable gaps separate a held phase from an advanced one.

Input changes made between clock edges show that the outputs respond combinationally. A reset raised in mid-wait shows that the return to idle happens without a clock edge. A direct sweep of all sixteen table addresses pins down the bit order and the contents of the unused phase-11 entries.

// File: rtl/wsg_pkg.sv
`timescale 1ns/1ps
package wsg_pkg;
  localparam int STATE_W = 2;
  localparam int CTRL_W  = 2;
  localparam int OUT_W   = 2;
  localparam int ADDR_W  = STATE_W + CTRL_W;
  localparam int WORD_W  = STATE_W + OUT_W;
  localparam int DEPTH   = 1 << ADDR_W;

  localparam logic [STATE_W-1:0] PH_IDLE  = 2'b00;
  localparam logic [STATE_W-1:0] PH_WAIT  = 2'b01;
  localparam logic [STATE_W-1:0] PH_DONE  = 2'b10;
  localparam logic [STATE_W-1:0] PH_SPARE = 2'b11;

  // word layout: {next phase, ret, ack}
  function automatic logic [WORD_W-1:0] wsg_entry(input logic [ADDR_W-1:0] a);
    logic [STATE_W-1:0] ph;
    logic               rq;
    logic               pw;
    logic [STATE_W-1:0] nxt;
    logic               r;
    logic               k;
    ph  = a[ADDR_W-1:CTRL_W];
    rq  = a[1];
    pw  = a[0];
    nxt = PH_IDLE;
    r   = 1'b0;
    k   = 1'b0;
    case (ph)
      PH_IDLE: begin
        if (!rq) begin
          nxt = PH_WAIT;
          r   = 1'b1;
        end
      end
      PH_WAIT: begin
        if (pw) begin
          nxt = PH_DONE;
          k   = 1'b1;
        end else begin
          nxt = PH_WAIT;
          r   = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
    return {nxt, r, k};
  endfunction
endpackage

// File: rtl/wsg_rom.sv
`timescale 1ns/1ps
module wsg_rom
  import wsg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  logic [WORD_W-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_q[i] = wsg_entry(ADDR_W'(i));
  end

  assign data = table_q[addr];
endmodule

// File: rtl/wsg_state_reg.sv
`timescale 1ns/1ps
module wsg_state_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R6: disabled register holds
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/wsg_top.sv
`timescale 1ns/1ps
module wsg_top
  import wsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic req,
  input  logic pwait,
  output logic ret,
  output logic ack
);
  logic [STATE_W-1:0] phase_q;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [WORD_W-1:0]  tbl_word;
  logic [STATE_W-1:0] phase_d;

  assign tbl_addr = {phase_q, req, pwait};

  wsg_rom u_rom (
    .addr (tbl_addr),
    .data (tbl_word)
  );

  assign phase_d = tbl_word[WORD_W-1:OUT_W];
  assign ret     = tbl_word[1];
  assign ack     = tbl_word[0];

  wsg_state_reg #(.W(STATE_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .en  (step_en),
    .d   (phase_d),
    .q   (phase_q)
  );

  // R4: handshake outputs exclusive
  p_ret_ack_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(ret && ack));

  // R4: an enabled acknowledge moves to the done phase
  p_ack_to_done_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && ack) |=> (phase_q == PH_DONE));

  // R5: done phase returns to idle on an enabled edge
  p_done_to_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

  // R9: spare phase is never reached
  p_no_spare_r9: assert property (@(posedge clk) disable iff (rst)
    phase_q != PH_SPARE);
endmodule

// File: tb/wsg_top_tb.sv
`timescale 1ns/1ps
module wsg_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic req = 1'b1;
  logic pwait = 1'b0;
  logic ret, ack;
  logic [3:0] rom_addr = 4'h0;
  logic [3:0] rom_data;

  int n_cmp = 0;
  int n_bad = 0;
  int model_ph = 0;   // 0 idle, 1 wait, 2 done
  bit finished = 0;

  always #2 clk = ~clk;

  wsg_top u_dut (
    .clk(clk), .rst(rst), .step_en(step_en),
    .req(req), .pwait(pwait), .ret(ret), .ack(ack)
  );

  wsg_rom u_rom (.addr(rom_addr), .data(rom_data));

  function automatic int exp_next(int ph, logic rq, logic pw);
    if (ph == 0) return rq ? 0 : 1;
    if (ph == 1) return pw ? 2 : 1;
    return 0;
  endfunction

  function automatic logic [1:0] exp_out(int ph, logic rq, logic pw);
    if (ph == 0 && !rq) return 2'b10;
    if (ph == 1) return pw ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_for(int ph, logic rq, logic pw);
    if (ph == 0) return rq ? "R1" : "R2";
    if (ph == 1) return pw ? "R4" : "R3";
    return "R5";
  endfunction

  task automatic compare(string tag);
    logic [1:0] e;
    e = exp_out(model_ph, req, pwait);
    n_cmp++;
    if ({ret, ack} !== e) begin
      n_bad++;
      $display("FAIL %s phase=%0d req=%b pwait=%b {ret,ack} actual=%b expected=%b",
               tag, model_ph, req, pwait, {ret, ack}, e);
    end
  endtask

  // drive at falling edge, compare 1 ns later, then take the rising edge
  task automatic step(logic rq, logic pw, logic en);
    string t;
    @(negedge clk);
    req = rq; pwait = pw; step_en = en;
    #1;
    t = en ? tag_for(model_ph, rq, pw) : "R6";
    compare(t);
    @(posedge clk);
    if (en) model_ph = exp_next(model_ph, rq, pw);
  endtask

  function automatic logic [3:0] exp_word(logic [3:0] a);
    logic [1:0] o;
    int n;
    n = exp_next(int'(a[3:2]), a[1], a[0]);
    o = exp_out(int'(a[3:2]), a[1], a[0]);
    return {2'(n), o};
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state (R7): idle with req high gives 00, req low gives ret
    #1;
    req = 1'b1; #0.5; compare("R7");
    req = 1'b0; #0.5; compare("R7");
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; req = 1'b1;

    // R1 idle hold, R2 start, R3 stretched wait, R4 ack, R5 return
    step(1, 0, 1);
    step(1, 1, 1);
    step(0, 0, 1);
    for (int i = 0; i < 6; i++) step(i[0], 0, 1);   // R3 with req toggling
    step(0, 1, 1);
    step(0, 1, 1);   // R5 in done with inputs active
    step(1, 1, 1);

    // R5 for every input combination
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1);
      step(1, 1, 1);
      step(k[1], k[0], 1);
    end

    // R6 enable low holds phase
    step(0, 0, 1);                       // now wait
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    step(1, 0, 1);                       // still wait (R3)
    step(0, 1, 1);                       // ack -> done
    step(0, 0, 0);                       // done held
    step(0, 0, 1);                       // done -> idle
    step(1, 0, 1);

    // R8 combinational response between edges, in wait phase
    step(0, 0, 1);                       // now wait
    @(negedge clk);
    step_en = 1'b0; req = 1'b1; pwait = 1'b0; #0.5; compare("R8");
    pwait = 1'b1; #0.5; compare("R8");
    pwait = 1'b0; #0.5; compare("R8");
    @(posedge clk);

    // R7 asynchronous reset from wait phase, between edges
    @(negedge clk);
    req = 1'b1; pwait = 1'b0; #0.5;
    compare("R3");
    rst = 1'b1; #0.5;
    model_ph = 0;
    compare("R7");
    @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic r, p, e;
      r = 1'($urandom);
      p = 1'($urandom);
      e = ($urandom % 5) != 0;
      step(r, p, e);
    end

    // R9 table sweep, bit orders and spare-phase entries
    for (int a = 0; a < 16; a++) begin
      rom_addr = 4'(a);
      #1;
      n_cmp++;
      if (rom_data !== exp_word(4'(a))) begin
        n_bad++;
        $display("FAIL R9 addr=%0d actual=%h expected=%h", a, rom_data, exp_word(4'(a)));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule